// File: doc/BRIEF.md
# Converter Calibrate/Convert Sequencer

This block is the control state machine that sits in front of a delta-sigma converter's filter and result port. It decides when the converter wakes up, when it calibrates, and when it converts. It also tells the surrounding datapath when each phase has finished. Two command pins drive it: calibrate and convert. A channel-select pin chooses the input, and its value is captured when a conversion is started. The internal logic steps on an enable that runs at half the master clock rate, so every duration is an even number of master cycles.

There are five internal states. WAKE is the power-up wait. IDLE is standby. CAL_OFS is the offset calibration step and CAL_GAIN is the gain calibration step. CONV is a conversion. The transitions are:

- *wake_done*: WAKE goes to IDLE, CAL_OFS or CONV, depending on the command remembered during the wait.
- *cal_start*: IDLE or CONV goes to CAL_OFS.
- *conv_start*: IDLE goes to CONV.
- *ofs_done*: CAL_OFS goes to CAL_GAIN.
- *gain_done*: CAL_GAIN goes to IDLE.
- *conv_restart*: CONV goes to CONV on a new convert edge.
- *conv_repeat*: CONV goes to CONV at completion while convert is held high.
- *conv_end*: CONV goes to IDLE.

The surrounding logic uses the offset, gain and conversion strobes to trigger the arithmetic and the result-port update, which are outside this block.

Top module: `cvt_sequencer`

## Requirements
- R1: While reset is asserted, state_o reads 0 and all three strobes and chan_o are 0. The state_o encoding is 0 for wake, 1 for standby, 2 for calibration (both steps) and 3 for conversion.
- R2: After reset is released, state_o stays at 0 for WAKE_CYCLES master cycles. If no command was seen, it then moves to 1.
- R3: Commands seen during the wake period are executed when it ends. Both pins high gives calibration. A convert rising edge gives a conversion on the channel that was present at that edge.
- R4: In standby, calibrate and convert both high starts calibration. If a convert edge arrives in the same step, calibration still wins.
- R5: Calibration runs an offset step of CAL_CYCLES that ends with a one-cycle ofs_done_o, then a gain step of CAL_CYCLES that ends with a one-cycle gain_done_o, then returns to standby.
- R6: A convert rising edge in standby latches chan_pin into chan_o and enters conversion within 5 master cycles, after two synchronizer flops and the half-rate phase.
- R7: conv_done_o pulses for exactly one master cycle, CONV_CYCLES master cycles after state_o becomes 3.
- R8: A convert rising edge during a conversion abandons it with no conv_done_o, latches the channel again, and restarts the full CONV_CYCLES count.
- R9: If convert is high when a conversion completes, the next conversion starts at once with the same channel, so successive conv_done_o pulses are CONV_CYCLES apart. If convert is low, the state returns to standby.
- R10: A convert edge during calibration is ignored: the state and chan_o are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| cal_pin | input | 1 | Calibrate command pin, asynchronous |
| conv_pin | input | 1 | Convert command pin, asynchronous |
| chan_pin | input | CHAN_W | Channel select, captured on a conversion start |
| state_o | output | 2 | Coarse state: 0 wake, 1 standby, 2 calibration, 3 conversion |
| chan_o | output | CHAN_W | Latched channel of the current or last conversion |
| ofs_done_o | output | 1 | One-cycle strobe at the end of the offset step |
| gain_done_o | output | 1 | One-cycle strobe at the end of the gain step |
| conv_done_o | output | 1 | One-cycle strobe telling the result port to update |

## Verification
The hardest situations to reach are the ones tied to the wake period. A command must be captured while the counter is still running, and it must be replayed only when the count expires. The stimulus therefore holds both pins high through reset release in one run. In a second run it produces a single channel-tagged convert pulse well inside the wake window and releases it before the window closes. The abort case is also delicate, because the abandoned conversion must never post a strobe. The bench expects only the channel of the restarted conversion in its scoreboard, so a stray strobe from the abandoned conversion shows up as a mismatch.

// File: rtl/cvt_seq_pkg.sv
package cvt_seq_pkg;

    typedef enum logic [2:0] {
        ST_WAKE,
        ST_IDLE,
        ST_CAL_OFS,
        ST_CAL_GAIN,
        ST_CONV
    } seq_state_t;

    typedef enum logic [1:0] {
        PEND_NONE,
        PEND_CAL,
        PEND_CONV
    } pend_t;

    localparam logic [1:0] CODE_WAKE = 2'd0;
    localparam logic [1:0] CODE_IDLE = 2'd1;
    localparam logic [1:0] CODE_CAL  = 2'd2;
    localparam logic [1:0] CODE_CONV = 2'd3;

endpackage

// File: rtl/cvt_half_en.sv
module cvt_half_en (
    input  logic clk,
    input  logic rst_n,
    output logic en_o
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_o <= 1'b0;
        else        en_o <= ~en_o;
    end

    // R6: the step enable alternates every master cycle
    p_en_alternate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        en_o |=> !en_o);
    p_en_return_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en_o |=> en_o);

endmodule

// File: rtl/cvt_cmd_sync.sv
module cvt_cmd_sync #(
    parameter int CHAN_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              cal_pin,
    input  logic              conv_pin,
    input  logic [CHAN_W-1:0] chan_pin,
    output logic              cal_both,
    output logic              conv_rise,
    output logic              conv_lvl,
    output logic [CHAN_W-1:0] chan_s
);

    localparam int VEC_W = CHAN_W + 2;

    logic [VEC_W-1:0] meta_q;
    logic [VEC_W-1:0] sync_q;
    logic             conv_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= {cal_pin, conv_pin, chan_pin};
            sync_q <= meta_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  conv_prev_q <= 1'b0;
        else if (en) conv_prev_q <= sync_q[CHAN_W];
    end

    assign conv_lvl  = sync_q[CHAN_W];
    assign chan_s    = sync_q[CHAN_W-1:0];
    assign cal_both  = sync_q[CHAN_W+1] & sync_q[CHAN_W];
    assign conv_rise = en & sync_q[CHAN_W] & ~conv_prev_q;

    // R6: an edge is reported on one step only
    p_rise_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        conv_rise |=> !conv_rise);

endmodule

// File: rtl/cvt_tick_cnt.sv
module cvt_tick_cnt #(
    parameter int               CNT_W   = 10,
    parameter logic [CNT_W-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic             zero
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                     cnt_q <= RST_VAL;
        else if (load)                  cnt_q <= load_val;
        else if (dec && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign zero = (cnt_q == '0);

    // R7: an expired count stays expired until reloaded
    p_hold_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (zero && !load) |=> zero);

endmodule

// File: rtl/cvt_sequencer.sv
module cvt_sequencer
    import cvt_seq_pkg::*;
#(
    parameter int CHAN_W      = 1,
    parameter int WAKE_CYCLES = 1800,
    parameter int CAL_CYCLES  = 1624,
    parameter int CONV_CYCLES = 1624
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cal_pin,
    input  logic              conv_pin,
    input  logic [CHAN_W-1:0] chan_pin,
    output logic [1:0]        state_o,
    output logic [CHAN_W-1:0] chan_o,
    output logic              ofs_done_o,
    output logic              gain_done_o,
    output logic              conv_done_o
);

    localparam int WAKE_TICKS = WAKE_CYCLES / 2;
    localparam int CAL_TICKS  = CAL_CYCLES / 2;
    localparam int CONV_TICKS = CONV_CYCLES / 2;
    localparam int MAX_A      = (WAKE_TICKS > CAL_TICKS) ? WAKE_TICKS : CAL_TICKS;
    localparam int MAX_TICKS  = (MAX_A > CONV_TICKS) ? MAX_A : CONV_TICKS;
    localparam int CNT_W      = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] WAKE_LD = CNT_W'(WAKE_TICKS - 1);
    localparam logic [CNT_W-1:0] CAL_LD  = CNT_W'(CAL_TICKS - 1);
    localparam logic [CNT_W-1:0] CONV_LD = CNT_W'(CONV_TICKS - 1);

    logic              en;
    logic              cal_both;
    logic              conv_rise;
    logic              conv_lvl;
    logic [CHAN_W-1:0] chan_s;
    logic              cnt_zero;

    seq_state_t        st_q, st_n;
    pend_t             pend_q, pend_eff;
    logic [CHAN_W-1:0] pchan_q, pchan_eff;
    logic [CHAN_W-1:0] chan_q;

    logic              load;
    logic [CNT_W-1:0]  ld_val;
    logic              set_chan, chan_from_pend;
    logic              ofs_n, gain_n, done_n;
    logic              ofs_q, gain_q, done_q;

    cvt_half_en u_en (
        .clk   (clk),
        .rst_n (rst_n),
        .en_o  (en)
    );

    cvt_cmd_sync #(.CHAN_W(CHAN_W)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cal_pin   (cal_pin),
        .conv_pin  (conv_pin),
        .chan_pin  (chan_pin),
        .cal_both  (cal_both),
        .conv_rise (conv_rise),
        .conv_lvl  (conv_lvl),
        .chan_s    (chan_s)
    );

    cvt_tick_cnt #(.CNT_W(CNT_W), .RST_VAL(WAKE_LD)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (ld_val),
        .dec      (en),
        .zero     (cnt_zero)
    );

    // Command remembered during wake, including the current step
    always_comb begin
        pend_eff  = pend_q;
        pchan_eff = pchan_q;
        if (cal_both) begin
            pend_eff = PEND_CAL;
        end else if (conv_rise && pend_q != PEND_CAL) begin
            pend_eff  = PEND_CONV;
            pchan_eff = chan_s;
        end
    end

    // Next-state and strobe decode
    always_comb begin
        st_n           = st_q;
        load           = 1'b0;
        ld_val         = '0;
        set_chan       = 1'b0;
        chan_from_pend = 1'b0;
        ofs_n          = 1'b0;
        gain_n         = 1'b0;
        done_n         = 1'b0;
        if (en) begin
            unique case (st_q)
                ST_WAKE: begin
                    if (cnt_zero) begin
                        if (pend_eff == PEND_CAL) begin
                            st_n   = ST_CAL_OFS;
                            load   = 1'b1;
                            ld_val = CAL_LD;
                        end else if (pend_eff == PEND_CONV) begin
                            st_n           = ST_CONV;
                            load           = 1'b1;
                            ld_val         = CONV_LD;
                            set_chan       = 1'b1;
                            chan_from_pend = 1'b1;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                end
                ST_IDLE: begin
                    if (cal_both) begin
                        st_n   = ST_CAL_OFS;
                        load   = 1'b1;
                        ld_val = CAL_LD;
                    end else if (conv_rise) begin
                        st_n     = ST_CONV;
                        load     = 1'b1;
                        ld_val   = CONV_LD;
                        set_chan = 1'b1;
                    end
                end
                ST_CAL_OFS: begin
                    if (cnt_zero) begin
                        ofs_n  = 1'b1;
                        st_n   = ST_CAL_GAIN;
                        load   = 1'b1;
                        ld_val = CAL_LD;
                    end
                end
                ST_CAL_GAIN: begin
                    if (cnt_zero) begin
                        gain_n = 1'b1;
                        st_n   = ST_IDLE;
                    end
                end
                ST_CONV: begin
                    if (cal_both) begin
                        st_n   = ST_CAL_OFS;
                        load   = 1'b1;
                        ld_val = CAL_LD;
                    end else if (conv_rise) begin
                        load     = 1'b1;
                        ld_val   = CONV_LD;
                        set_chan = 1'b1;
                    end else if (cnt_zero) begin
                        done_n = 1'b1;
                        if (conv_lvl) begin
                            load   = 1'b1;
                            ld_val = CONV_LD;
                        end else begin
                            st_n = ST_IDLE;
                        end
                    end
                end
                default: st_n = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_WAKE;
        else        st_q <= st_n;
    end

    // Output and capture registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ofs_q   <= 1'b0;
            gain_q  <= 1'b0;
            done_q  <= 1'b0;
            chan_q  <= '0;
            pend_q  <= PEND_NONE;
            pchan_q <= '0;
        end else begin
            ofs_q  <= ofs_n;
            gain_q <= gain_n;
            done_q <= done_n;
            if (set_chan) chan_q <= chan_from_pend ? pchan_eff : chan_s;
            if (en && st_q == ST_WAKE) begin
                pend_q  <= pend_eff;
                pchan_q <= pchan_eff;
            end
        end
    end

    always_comb begin
        unique case (st_q)
            ST_WAKE:                 state_o = CODE_WAKE;
            ST_IDLE:                 state_o = CODE_IDLE;
            ST_CAL_OFS, ST_CAL_GAIN: state_o = CODE_CAL;
            ST_CONV:                 state_o = CODE_CONV;
            default:                 state_o = CODE_IDLE;
        endcase
    end

    assign chan_o      = chan_q;
    assign ofs_done_o  = ofs_q;
    assign gain_done_o = gain_q;
    assign conv_done_o = done_q;

    logic in_cal;
    assign in_cal = (st_q == ST_CAL_OFS) || (st_q == ST_CAL_GAIN);

    p_wake_exit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q == ST_WAKE) && st_q != ST_WAKE) |-> $past(cnt_zero));
    p_strobe_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ofs_q, gain_q, done_q}));
    p_ofs_then_gain_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ofs_q |-> st_q == ST_CAL_GAIN);
    p_gain_then_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        gain_q |-> st_q == ST_IDLE);
    p_done_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    p_done_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> (st_q == ST_CONV || st_q == ST_IDLE));
    p_chan_hold_cal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cal && $past(in_cal)) |-> $stable(chan_q));

endmodule

// File: tb/sim_cvt_sequencer.sv
module sim_cvt_sequencer;

    localparam int CLK_PERIOD = 10;
    localparam int WAKE = 1800;
    localparam int CALC = 1624;
    localparam int CONVC = 1624;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cal_pin = 1'b0;
    logic       conv_pin = 1'b0;
    logic [0:0] chan_pin = 1'b0;
    logic [1:0] state_o;
    logic [0:0] chan_o;
    logic       ofs_done_o, gain_done_o, conv_done_o;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int exp_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    cvt_sequencer #(.CHAN_W(1), .WAKE_CYCLES(WAKE), .CAL_CYCLES(CALC),
                    .CONV_CYCLES(CONVC)) u0 (
        .clk(clk), .rst_n(rst_n), .cal_pin(cal_pin), .conv_pin(conv_pin),
        .chan_pin(chan_pin), .state_o(state_o), .chan_o(chan_o),
        .ofs_done_o(ofs_done_o), .gain_done_o(gain_done_o),
        .conv_done_o(conv_done_o)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // kind: 0 offset, 1 gain, 2 conversion (with channel)
    task automatic push_exp(input int kind, input int ch);
        exp_q.push_back(kind * 16 + ch);
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && (ofs_done_o || gain_done_o || conv_done_o)) begin
            int kind;
            int got;
            int e;
            kind = ofs_done_o ? 0 : (gain_done_o ? 1 : 2);
            got  = kind * 16 + ((kind == 2) ? int'(chan_o) : 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, (kind == 2) ? "R8" : "R5", "unexpected strobe", got, -1);
            end else begin
                e = exp_q.pop_front();
                chk(got == e, (kind == 2) ? "R7" : "R5", "strobe kind/channel", got, e);
            end
        end
    end

    function automatic bit strobe(input int kind);
        if (kind == 0) return ofs_done_o;
        if (kind == 1) return gain_done_o;
        return conv_done_o;
    endfunction

    task automatic wait_state(input logic [1:0] code, input int limit, output int n);
        n = 0;
        while (state_o != code && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic wait_strobe(input int kind, input int limit);
        int n;
        n = 0;
        @(negedge clk);
        while (!strobe(kind) && n < limit) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (4) @(negedge clk);
        chk(state_o == 2'd0, "R1", "state in reset", state_o, 0);
        chk({ofs_done_o, gain_done_o, conv_done_o} == 3'b000, "R1", "strobes in reset",
            {ofs_done_o, gain_done_o, conv_done_o}, 0);
        chk(chan_o == 1'b0, "R1", "channel in reset", chan_o, 0);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=expired expected=finished");
        summary();
        $finish;
    end

    initial begin
        int n, t0, t1, t2, tr;

        // Phase A: plain wake (R1, R2)
        do_reset();
        wait_state(2'd1, 3000, n);
        chk(n >= WAKE - 2 && n <= WAKE + 2, "R2", "wake length", n, WAKE);
        chk(state_o == 2'd1, "R2", "standby after wake", state_o, 1);

        // Phase B: calibration, with priority and an ignored convert edge (R4, R5, R10)
        repeat (5) @(negedge clk);
        cal_pin = 1'b1; conv_pin = 1'b1;
        push_exp(0, 0); push_exp(1, 0);
        wait_state(2'd2, 20, n);
        t0 = cyc;
        chk(state_o == 2'd2 && n <= 5, "R4", "calibration wins over convert edge", n, 5);
        repeat (10) @(negedge clk);
        cal_pin = 1'b0; conv_pin = 1'b0;
        repeat (100) @(negedge clk);
        chan_pin = 1'b1; conv_pin = 1'b1;
        repeat (6) @(negedge clk);
        conv_pin = 1'b0;
        repeat (6) @(negedge clk);
        chk(state_o == 2'd2, "R10", "state after convert edge in calibration", state_o, 2);
        chk(chan_o == 1'b0, "R10", "channel after convert edge in calibration", chan_o, 0);
        wait_strobe(0, 4000);
        t1 = cyc;
        chk(t1 - t0 == CALC, "R5", "offset step length", t1 - t0, CALC);
        chk(state_o == 2'd2, "R5", "still calibrating in gain step", state_o, 2);
        wait_strobe(1, 4000);
        t2 = cyc;
        chk(t2 - t1 == CALC, "R5", "gain step length", t2 - t1, CALC);
        @(negedge clk);
        chk(state_o == 2'd1, "R5", "standby after calibration", state_o, 1);

        // Phase C: start, timing, back-to-back (R6, R7, R9)
        repeat (4) @(negedge clk);
        conv_pin = 1'b1;
        tr = cyc;
        push_exp(2, 1); push_exp(2, 1);
        wait_state(2'd3, 20, n);
        t0 = cyc;
        chk(state_o == 2'd3 && (t0 - tr) <= 5, "R6", "conversion start latency", t0 - tr, 5);
        chk(chan_o == 1'b1, "R6", "latched channel", chan_o, 1);
        repeat (20) @(negedge clk);
        chan_pin = 1'b0;
        wait_strobe(2, 4000);
        t1 = cyc;
        chk(t1 - t0 == CONVC, "R7", "conversion length", t1 - t0, CONVC);
        @(negedge clk);
        chk(conv_done_o == 1'b0, "R7", "strobe width", conv_done_o, 0);
        chk(state_o == 2'd3, "R9", "back-to-back restart", state_o, 3);
        repeat (100) @(negedge clk);
        conv_pin = 1'b0;
        wait_strobe(2, 4000);
        t2 = cyc;
        chk(t2 - t1 == CONVC, "R9", "back-to-back interval", t2 - t1, CONVC);
        @(negedge clk);
        chk(state_o == 2'd1, "R9", "standby after convert released", state_o, 1);

        // Phase D: abort and restart (R8)
        repeat (4) @(negedge clk);
        conv_pin = 1'b1;
        push_exp(2, 1);
        wait_state(2'd3, 20, n);
        repeat (500) @(negedge clk);
        conv_pin = 1'b0; chan_pin = 1'b1;
        repeat (6) @(negedge clk);
        conv_pin = 1'b1;
        tr = cyc;
        repeat (8) @(negedge clk);
        conv_pin = 1'b0;
        chk(chan_o == 1'b1, "R8", "channel relatched on restart", chan_o, 1);
        chk(state_o == 2'd3, "R8", "still converting after restart", state_o, 3);
        wait_strobe(2, 4000);
        chk((cyc - tr) >= CONVC + 1 && (cyc - tr) <= CONVC + 5, "R8",
            "restarted conversion length", cyc - tr, CONVC + 3);
        @(negedge clk);
        chk(state_o == 2'd1, "R8", "standby after restarted conversion", state_o, 1);

        // Phase E: calibrate command held through wake (R3)
        cal_pin = 1'b1; conv_pin = 1'b1;
        do_reset();
        push_exp(0, 0); push_exp(1, 0);
        wait_state(2'd2, 3000, n);
        chk(state_o == 2'd2 && n >= WAKE - 2 && n <= WAKE + 2, "R3",
            "calibration after wake", n, WAKE);
        repeat (100) @(negedge clk);
        cal_pin = 1'b0; conv_pin = 1'b0;
        wait_strobe(1, 5000);
        @(negedge clk);
        chk(state_o == 2'd1, "R3", "standby after remembered calibration", state_o, 1);

        // Phase F: convert edge during wake (R3)
        chan_pin = 1'b0;
        do_reset();
        repeat (200) @(negedge clk);
        chan_pin = 1'b1;
        repeat (4) @(negedge clk);
        conv_pin = 1'b1;
        repeat (100) @(negedge clk);
        conv_pin = 1'b0; chan_pin = 1'b0;
        chk(state_o == 2'd0, "R3", "still waking when command given", state_o, 0);
        push_exp(2, 1);
        wait_state(2'd3, 3000, n);
        chk(state_o == 2'd3, "R3", "conversion after wake", state_o, 3);
        chk(chan_o == 1'b1, "R3", "remembered channel", chan_o, 1);
        wait_strobe(2, 4000);
        @(negedge clk);
        chk(state_o == 2'd1, "R3", "standby after remembered conversion", state_o, 1);

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R7", "scoreboard drained", exp_q.size(), 0);
        summary();
        $finish;
    end

endmodule